// File: doc/BRIEF.md
# Multi-View General-Purpose Register Bank

This block is the working register storage of a small 8-bit RISC core. It holds thirty-two byte-wide registers and lets the execute stage read two operands and write one result in the same clock. The ALU, the instruction decoder, the program memory and the peripherals are outside the block.

The same thirty-two bytes can also be reached in two other ways. The top six registers pair up into three 16-bit indirect pointers, which can be read and written as whole words. The lowest data-space addresses reach the registers as if they were ordinary memory. The block also decodes the data-space window just above the registers into a 6-bit peripheral register index, accepts a direct 6-bit peripheral number for the same window, and flags every address above that window for external data memory. Every read port shows the value that the addressed register will hold after the coming clock edge, so a dependent operation in the next instruction needs no stall.

Top module: `regbank_mm`

## Requirements
- R1: There are 32 registers of 8 bits each. `rd_a_data` and `rd_b_data` show the registers numbered `rd_a_num` and `rd_b_num`. A register-number write of `wr_data` into register `wr_num` takes effect at the rising clock edge only while `wr_en` is 1.
- R2: Every read output (`rd_a_data`, `rd_b_data`, `ptr_rdata`, `z_ptr`, `ds_rdata`) shows the value that the addressed register will hold after the next rising edge. A write in the current cycle is therefore visible on the read outputs in that same cycle.
- R3: `ptr_sel` encodes 0 for pointer X (registers 27:26), 1 for Y (29:28) and 2 for Z (31:30). In each pair the even register is the low byte. `ptr_rdata` returns the selected pair as {odd, even}.
- R4: When `ptr_we` is 1 and `ptr_sel` is 0 to 2, both bytes of the selected pair are loaded from `ptr_wdata` at the same edge. `ptr_sel` = 3 makes a pointer write change nothing and drives `ptr_rdata` to 0.
- R5: When two writes reach the same register in one cycle, the pointer write wins over the register-number write, and the register-number write wins over a data-space write.
- R6: `z_ptr` always carries the Z pointer {register 31, register 30}, so that constant-table lookups can use it.
- R7: With `ds_en` = 1, addresses 0x00 to 0x1F raise `ds_rf_sel`. A data-space read returns register `ds_addr[4:0]` on `ds_rdata`, and a write with `ds_we` = 1 stores `ds_wdata` there. At any other address `ds_rdata` is 0.
- R8: With `ds_en` = 1, addresses 0x20 to 0x5F raise `io_sel` with `io_idx` = address − 0x20. `ds_rf_sel` and `ext_sel` stay 0, and a data-space write in this window changes no register.
- R9: With `io_dir_en` = 1, `io_sel` is 1 and `io_idx` equals `io_dir_num`. This takes priority over any index decoded from `ds_addr`.
- R10: With `ds_en` = 1, addresses 0x60 and above raise only `ext_sel`. With `ds_en` = 0, `ds_rf_sel` and `ext_sel` are 0, and `io_sel` follows R9 alone.
- R11: An active-low `rst_n` clears all registers to zero at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_num | input | 5 | Operand A register number |
| rd_a_data | output | 8 | Operand A value |
| rd_b_num | input | 5 | Operand B register number |
| rd_b_data | output | 8 | Operand B value |
| wr_en | input | 1 | Register-number write enable |
| wr_num | input | 5 | Register number to write |
| wr_data | input | 8 | Result byte to write |
| ptr_sel | input | 2 | Pointer select (0 X, 1 Y, 2 Z, 3 none) |
| ptr_we | input | 1 | Pointer word write enable |
| ptr_wdata | input | 16 | Pointer word to write |
| ptr_rdata | output | 16 | Selected pointer word |
| z_ptr | output | 16 | Z pointer for constant lookups |
| ds_en | input | 1 | Data-space access valid |
| ds_we | input | 1 | Data-space write |
| ds_addr | input | 16 | Data-space address |
| ds_wdata | input | 8 | Data-space write byte |
| ds_rdata | output | 8 | Register byte read through data space |
| ds_rf_sel | output | 1 | Address hits the register window |
| io_dir_en | input | 1 | Direct peripheral access valid |
| io_dir_num | input | 6 | Direct peripheral register number |
| io_sel | output | 1 | Peripheral register selected |
| io_idx | output | 6 | Peripheral register index |
| ext_sel | output | 1 | Address goes to external data memory |

## Verification
A vector table writes into low, middle and top registers, including the Z bytes. It disables the write enable while the data changes, which shows a gated write apart from a missing enable, and it reads the register being written, which separates the write-through path from a registered read. Directed tests then write whole pointers and stage same-cycle collisions, pointer against number port and number port against data space, which exposes a wrong priority order. Data-space probes at both edges of each window (0x1F/0x20, 0x5F/0x60), a write at 0x25 that aliases register 5 in its low bits, direct peripheral numbers with and without a competing address, an illegal pointer select and an asynchronous reset catch off-by-one decoding, address aliasing and ignored inputs leaking through.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int DW        = 8;
  localparam int RF_N      = 32;
  localparam int RF_AW     = $clog2(RF_N);
  localparam int PW        = 2 * DW;
  localparam int DSW       = 16;
  localparam int IO_N      = 64;
  localparam int IO_AW     = $clog2(IO_N);
  localparam int IO_BASE   = RF_N;
  localparam int EXT_BASE  = IO_BASE + IO_N;
  localparam int PTR_N     = 3;
  localparam int PSW       = 2;
  localparam int PTR_BASE  = RF_N - 2 * PTR_N;

  typedef logic [RF_N-1:0][DW-1:0] rf_arr_t;

  typedef struct packed {
    logic             rf;
    logic             io;
    logic             ext;
    logic [RF_AW-1:0] rf_idx;
    logic [IO_AW-1:0] io_idx;
  } ds_dec_t;

  // Split a data-space address into register, peripheral or external ranges.
  function automatic ds_dec_t ds_decode(input logic [DSW-1:0] addr);
    ds_dec_t        d;
    logic [DSW-1:0] off;
    d   = '0;
    off = addr - DSW'(IO_BASE);
    if (addr < DSW'(IO_BASE)) begin
      d.rf     = 1'b1;
      d.rf_idx = addr[RF_AW-1:0];
    end else if (addr < DSW'(EXT_BASE)) begin
      d.io     = 1'b1;
      d.io_idx = off[IO_AW-1:0];
    end else begin
      d.ext    = 1'b1;
    end
    return d;
  endfunction

  // Low-byte register number of a pointer pair.
  function automatic logic [RF_AW-1:0] pair_lo(input logic [PSW-1:0] sel);
    return RF_AW'(PTR_BASE + 2 * int'(sel));
  endfunction

  function automatic logic ptr_legal(input logic [PSW-1:0] sel);
    return int'(sel) < PTR_N;
  endfunction
endpackage

// File: rtl/regbank_decode.sv
module regbank_decode
  import regbank_pkg::*;
(
  input  logic             ds_en,
  input  logic [DSW-1:0]   ds_addr,
  input  logic             io_dir_en,
  input  logic [IO_AW-1:0] io_dir_num,
  output logic             rf_hit,
  output logic [RF_AW-1:0] rf_idx,
  output logic             io_sel,
  output logic [IO_AW-1:0] io_idx,
  output logic             ext_sel
);
  ds_dec_t dec;

  always_comb begin
    dec     = ds_decode(ds_addr);
    rf_hit  = ds_en & dec.rf;
    rf_idx  = dec.rf_idx;
    ext_sel = ds_en & dec.ext;
    if (io_dir_en) begin
      io_sel = 1'b1;
      io_idx = io_dir_num;
    end else begin
      io_sel = ds_en & dec.io;
      io_idx = (ds_en & dec.io) ? dec.io_idx : '0;
    end
  end
endmodule

// File: rtl/regbank_wmerge.sv
module regbank_wmerge
  import regbank_pkg::*;
(
  input  rf_arr_t          cur_q,
  input  logic             ptr_fire,
  input  logic [RF_AW-1:0] ptr_lo,
  input  logic [RF_AW-1:0] ptr_hi,
  input  logic [PW-1:0]    ptr_wdata,
  input  logic             num_fire,
  input  logic [RF_AW-1:0] num_idx,
  input  logic [DW-1:0]    num_wdata,
  input  logic             ds_fire,
  input  logic [RF_AW-1:0] ds_idx,
  input  logic [DW-1:0]    ds_wdata,
  output rf_arr_t          nxt,
  output logic             ptr_hits_num,
  output logic             num_hits_ds
);
  always_comb begin
    for (int i = 0; i < RF_N; i++) begin
      if (ptr_fire && ptr_lo == RF_AW'(i))
        nxt[i] = ptr_wdata[DW-1:0];
      else if (ptr_fire && ptr_hi == RF_AW'(i))
        nxt[i] = ptr_wdata[PW-1:DW];
      else if (num_fire && num_idx == RF_AW'(i))
        nxt[i] = num_wdata;
      else if (ds_fire && ds_idx == RF_AW'(i))
        nxt[i] = ds_wdata;
      else
        nxt[i] = cur_q[i];
    end
  end

  assign ptr_hits_num = ptr_fire & num_fire & ((num_idx == ptr_lo) | (num_idx == ptr_hi));
  assign num_hits_ds  = num_fire & ds_fire & (num_idx == ds_idx);
endmodule

// File: rtl/regbank_store.sv
module regbank_store
  import regbank_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  rf_arr_t d,
  output rf_arr_t q
);
  for (genvar i = 0; i < RF_N; i++) begin : g_cell
    logic [DW-1:0] cell_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cell_q <= '0;
      else        cell_q <= d[i];
    end
    assign q[i] = cell_q;
  end
endmodule

// File: rtl/regbank_mm.sv
module regbank_mm
  import regbank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RF_AW-1:0] rd_a_num,
  output logic [DW-1:0]    rd_a_data,
  input  logic [RF_AW-1:0] rd_b_num,
  output logic [DW-1:0]    rd_b_data,
  input  logic             wr_en,
  input  logic [RF_AW-1:0] wr_num,
  input  logic [DW-1:0]    wr_data,
  input  logic [PSW-1:0]   ptr_sel,
  input  logic             ptr_we,
  input  logic [PW-1:0]    ptr_wdata,
  output logic [PW-1:0]    ptr_rdata,
  output logic [PW-1:0]    z_ptr,
  input  logic             ds_en,
  input  logic             ds_we,
  input  logic [DSW-1:0]   ds_addr,
  input  logic [DW-1:0]    ds_wdata,
  output logic [DW-1:0]    ds_rdata,
  output logic             ds_rf_sel,
  input  logic             io_dir_en,
  input  logic [IO_AW-1:0] io_dir_num,
  output logic             io_sel,
  output logic [IO_AW-1:0] io_idx,
  output logic             ext_sel
);
  localparam logic [RF_AW-1:0] Z_LO = pair_lo(PSW'(PTR_N - 1));
  localparam logic [RF_AW-1:0] Z_HI = Z_LO + RF_AW'(1);

  rf_arr_t          regs_q;
  rf_arr_t          regs_nxt;
  logic [RF_AW-1:0] ds_idx;
  logic [RF_AW-1:0] ptr_lo;
  logic [RF_AW-1:0] ptr_hi;
  logic             ptr_ok;
  logic             ptr_wr_fire;
  logic             num_wr_fire;
  logic             ds_wr_fire;
  logic             ptr_hits_num;
  logic             num_hits_ds;

  regbank_decode u_dec (
    .ds_en      (ds_en),
    .ds_addr    (ds_addr),
    .io_dir_en  (io_dir_en),
    .io_dir_num (io_dir_num),
    .rf_hit     (ds_rf_sel),
    .rf_idx     (ds_idx),
    .io_sel     (io_sel),
    .io_idx     (io_idx),
    .ext_sel    (ext_sel)
  );

  assign ptr_ok      = ptr_legal(ptr_sel);
  assign ptr_lo      = pair_lo(ptr_sel);
  assign ptr_hi      = ptr_lo + RF_AW'(1);
  assign ptr_wr_fire = ptr_we & ptr_ok;
  assign num_wr_fire = wr_en;
  assign ds_wr_fire  = ds_rf_sel & ds_we;

  regbank_wmerge u_wm (
    .cur_q        (regs_q),
    .ptr_fire     (ptr_wr_fire),
    .ptr_lo       (ptr_lo),
    .ptr_hi       (ptr_hi),
    .ptr_wdata    (ptr_wdata),
    .num_fire     (num_wr_fire),
    .num_idx      (wr_num),
    .num_wdata    (wr_data),
    .ds_fire      (ds_wr_fire),
    .ds_idx       (ds_idx),
    .ds_wdata     (ds_wdata),
    .nxt          (regs_nxt),
    .ptr_hits_num (ptr_hits_num),
    .num_hits_ds  (num_hits_ds)
  );

  regbank_store u_st (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (regs_nxt),
    .q     (regs_q)
  );

  // All reads look at the post-edge value (write-through).
  assign rd_a_data = regs_nxt[rd_a_num];
  assign rd_b_data = regs_nxt[rd_b_num];
  assign ptr_rdata = ptr_ok ? {regs_nxt[ptr_hi], regs_nxt[ptr_lo]} : '0;
  assign z_ptr     = {regs_nxt[Z_HI], regs_nxt[Z_LO]};
  assign ds_rdata  = ds_rf_sel ? regs_nxt[ds_idx] : '0;
endmodule

// File: rtl/regbank_chk.sv
module regbank_chk
  import regbank_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input rf_arr_t          regs_q,
  input logic             num_wr_fire,
  input logic             ptr_wr_fire,
  input logic             ptr_hits_num,
  input logic             num_hits_ds,
  input logic [RF_AW-1:0] wr_num,
  input logic [DW-1:0]    wr_data,
  input logic [RF_AW-1:0] ptr_lo,
  input logic [PW-1:0]    ptr_wdata,
  input logic [PW-1:0]    z_ptr,
  input logic             ds_en,
  input logic             ds_we,
  input logic [DSW-1:0]   ds_addr,
  input logic             ds_rf_sel,
  input logic             io_dir_en,
  input logic             io_sel,
  input logic [IO_AW-1:0] io_idx,
  input logic             ext_sel,
  input logic             wr_en,
  input logic             ptr_we
);
  // R1 and R5: a number-port write lands unless a pointer write covers it
  a_r1_num_write: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(num_wr_fire) && !$past(ptr_hits_num))
      |-> regs_q[$past(wr_num)] == $past(wr_data));

  // R5: the pointer write wins in its pair
  a_r5_ptr_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ptr_wr_fire))
      |-> {regs_q[$past(ptr_lo) + RF_AW'(1)], regs_q[$past(ptr_lo)]} == $past(ptr_wdata));

  // R5: the number port beats the data-space write
  a_r5_num_over_ds: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(num_hits_ds) && !$past(ptr_hits_num))
      |-> regs_q[$past(wr_num)] == $past(wr_data));

  // R6: Z output equals the pair value after the edge
  a_r6_z_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> {regs_q[RF_N-1], regs_q[RF_N-2]} == $past(z_ptr));

  // R8: decoded index plus window base gives back the address
  a_r8_io_index: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_en && io_sel && !io_dir_en)
      |-> (DSW'(io_idx) + DSW'(IO_BASE)) == ds_addr);

  // R8: a write into the peripheral window leaves the registers alone
  a_r8_io_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ds_en && ds_we && io_sel && !io_dir_en && !wr_en && !ptr_we))
      |-> regs_q == $past(regs_q));

  // R10: at most one target window without a direct peripheral access
  a_r10_one_window: assert property (@(posedge clk) disable iff (!rst_n)
    !io_dir_en |-> $onehot0({ds_rf_sel, io_sel, ext_sel}));

  // R11: registers are zero while reset is held
  always @(posedge clk) begin
    if (!rst_n) a_r11_reset_clear: assert (regs_q == '0);
  end
endmodule

bind regbank_mm regbank_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .regs_q       (regs_q),
  .num_wr_fire  (num_wr_fire),
  .ptr_wr_fire  (ptr_wr_fire),
  .ptr_hits_num (ptr_hits_num),
  .num_hits_ds  (num_hits_ds),
  .wr_num       (wr_num),
  .wr_data      (wr_data),
  .ptr_lo       (ptr_lo),
  .ptr_wdata    (ptr_wdata),
  .z_ptr        (z_ptr),
  .ds_en        (ds_en),
  .ds_we        (ds_we),
  .ds_addr      (ds_addr),
  .ds_rf_sel    (ds_rf_sel),
  .io_dir_en    (io_dir_en),
  .io_sel       (io_sel),
  .io_idx       (io_idx),
  .ext_sel      (ext_sel),
  .wr_en        (wr_en),
  .ptr_we       (ptr_we)
);

// File: tb/regbank_mm_tb.sv
module regbank_mm_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  rd_a_num, rd_b_num, wr_num;
  logic [7:0]  rd_a_data, rd_b_data, wr_data, ds_wdata, ds_rdata;
  logic        wr_en, ptr_we, ds_en, ds_we, io_dir_en;
  logic [1:0]  ptr_sel;
  logic [15:0] ptr_wdata, ptr_rdata, z_ptr, ds_addr;
  logic        ds_rf_sel, io_sel, ext_sel;
  logic [5:0]  io_dir_num, io_idx;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  regbank_mm u_dut (
    .clk(clk), .rst_n(rst_n),
    .rd_a_num(rd_a_num), .rd_a_data(rd_a_data),
    .rd_b_num(rd_b_num), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_num(wr_num), .wr_data(wr_data),
    .ptr_sel(ptr_sel), .ptr_we(ptr_we), .ptr_wdata(ptr_wdata),
    .ptr_rdata(ptr_rdata), .z_ptr(z_ptr),
    .ds_en(ds_en), .ds_we(ds_we), .ds_addr(ds_addr), .ds_wdata(ds_wdata),
    .ds_rdata(ds_rdata), .ds_rf_sel(ds_rf_sel),
    .io_dir_en(io_dir_en), .io_dir_num(io_dir_num),
    .io_sel(io_sel), .io_idx(io_idx), .ext_sel(ext_sel)
  );

  typedef struct packed {
    logic       we;
    logic [4:0] wn;
    logic [7:0] wd;
    logic [4:0] ra;
    logic [4:0] rb;
    logic [7:0] ea;
    logic [7:0] eb;
  } vec_t;

  // Checked in the write cycle itself, so each row also exercises R2.
  localparam vec_t VT [8] = '{
    '{1'b1, 5'd5,  8'hA5, 5'd5,  5'd0,  8'hA5, 8'h00},
    '{1'b1, 5'd0,  8'h3C, 5'd5,  5'd0,  8'hA5, 8'h3C},
    '{1'b0, 5'd5,  8'hFF, 5'd5,  5'd0,  8'hA5, 8'h3C},
    '{1'b1, 5'd31, 8'h81, 5'd31, 5'd30, 8'h81, 8'h00},
    '{1'b1, 5'd30, 8'h7E, 5'd30, 5'd31, 8'h7E, 8'h81},
    '{1'b1, 5'd5,  8'h00, 5'd5,  5'd5,  8'h00, 8'h00},
    '{1'b1, 5'd17, 8'hC3, 5'd0,  5'd17, 8'h3C, 8'hC3},
    '{1'b0, 5'd0,  8'h00, 5'd31, 5'd30, 8'h81, 8'h7E}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; wr_num = 0; wr_data = 0;
    ptr_we = 0; ptr_sel = 0; ptr_wdata = 0;
    ds_en = 0; ds_we = 0; ds_addr = 0; ds_wdata = 0;
    io_dir_en = 0; io_dir_num = 0;
    rd_a_num = 0; rd_b_num = 0;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle();
    rd_a_num = 5'd31;
    repeat (3) @(negedge clk);
    #1;
    chk("R11 reset reg31", {8'h0, rd_a_data}, 16'h0000);
    chk("R11 reset z", z_ptr, 16'h0000);
    rst_n = 1'b1;

    for (int i = 0; i < 8; i++) begin
      step();
      wr_en = VT[i].we; wr_num = VT[i].wn; wr_data = VT[i].wd;
      rd_a_num = VT[i].ra; rd_b_num = VT[i].rb;
      #1;
      chk($sformatf("R1 R2 vec%0d a", i), {8'h0, rd_a_data}, {8'h0, VT[i].ea});
      chk($sformatf("R1 R2 vec%0d b", i), {8'h0, rd_b_data}, {8'h0, VT[i].eb});
    end

    step(); ptr_sel = 2'd2; #1;
    chk("R6 z output", z_ptr, 16'h817E);
    chk("R3 read Z", ptr_rdata, 16'h817E);

    step(); ptr_we = 1; ptr_sel = 2'd0; ptr_wdata = 16'h1234; #1;
    chk("R2 pointer bypass", ptr_rdata, 16'h1234);
    step(); rd_a_num = 5'd26; rd_b_num = 5'd27; #1;
    chk("R3 X low byte r26", {8'h0, rd_a_data}, 16'h0034);
    chk("R4 X high byte r27", {8'h0, rd_b_data}, 16'h0012);

    step(); ptr_we = 1; ptr_sel = 2'd1; ptr_wdata = 16'hABCD;
    wr_en = 1; wr_num = 5'd28; wr_data = 8'h55;
    step(); rd_a_num = 5'd28; rd_b_num = 5'd29; #1;
    chk("R5 pointer beats number r28", {8'h0, rd_a_data}, 16'h00CD);
    chk("R5 pointer high r29", {8'h0, rd_b_data}, 16'h00AB);

    step(); wr_en = 1; wr_num = 5'd7; wr_data = 8'h11;
    ds_en = 1; ds_we = 1; ds_addr = 16'h0007; ds_wdata = 8'h22;
    step(); rd_a_num = 5'd7; #1;
    chk("R5 number beats data space", {8'h0, rd_a_data}, 16'h0011);

    step(); ds_en = 1; ds_we = 1; ds_addr = 16'h0003; ds_wdata = 8'h99;
    step(); rd_a_num = 5'd3; ds_en = 1; ds_addr = 16'h001F; #1;
    chk("R7 data-space write r3", {8'h0, rd_a_data}, 16'h0099);
    chk("R7 data-space read 0x1F", {8'h0, ds_rdata}, 16'h0081);
    chk("R7 rf select", {15'h0, ds_rf_sel}, 16'h1);

    step(); ds_en = 1; ds_addr = 16'h0020; #1;
    chk("R8 io at 0x20", {ds_rf_sel, ext_sel, io_sel, 7'h0, io_idx}, {3'b001, 7'h0, 6'd0});
    step(); ds_en = 1; ds_addr = 16'h005F; #1;
    chk("R8 io at 0x5F", {ds_rf_sel, ext_sel, io_sel, 7'h0, io_idx}, {3'b001, 7'h0, 6'd63});
    step(); ds_en = 1; ds_we = 1; ds_addr = 16'h0025; ds_wdata = 8'hEE; #1;
    chk("R8 no rf read data in io window", {8'h0, ds_rdata}, 16'h0000);
    step(); rd_a_num = 5'd5; #1;
    chk("R8 io write leaves r5", {8'h0, rd_a_data}, 16'h0000);

    step(); ds_en = 1; ds_addr = 16'h0060; #1;
    chk("R10 ext at 0x60", {13'h0, ds_rf_sel, io_sel, ext_sel}, 16'h0001);
    step(); ds_en = 1; ds_addr = 16'hFFFF; #1;
    chk("R10 ext at 0xFFFF", {13'h0, ds_rf_sel, io_sel, ext_sel}, 16'h0001);
    step(); ds_en = 0; ds_addr = 16'h0004; #1;
    chk("R10 no select when idle", {13'h0, ds_rf_sel, io_sel, ext_sel}, 16'h0000);

    step(); io_dir_en = 1; io_dir_num = 6'h2A; #1;
    chk("R9 direct io", {9'h0, io_sel, io_idx}, {9'h0, 1'b1, 6'h2A});
    step(); io_dir_en = 1; io_dir_num = 6'h05; ds_en = 1; ds_addr = 16'h0040; #1;
    chk("R9 direct overrides address", {9'h0, io_sel, io_idx}, {9'h0, 1'b1, 6'h05});

    step(); ptr_we = 1; ptr_sel = 2'd3; ptr_wdata = 16'hFFFF; #1;
    chk("R4 illegal select reads zero", ptr_rdata, 16'h0000);
    step(); ptr_sel = 2'd0; #1;
    chk("R4 X after illegal write", ptr_rdata, 16'h1234);
    step(); ptr_sel = 2'd1; #1;
    chk("R4 Y after illegal write", ptr_rdata, 16'hABCD);
    chk("R4 Z after illegal write", z_ptr, 16'h817E);

    step(); rd_a_num = 5'd31; #1;
    rst_n = 1'b0; #0.5;
    chk("R11 async clear r31", {8'h0, rd_a_data}, 16'h0000);
    chk("R11 async clear z", z_ptr, 16'h0000);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule